// File: doc/BRIEF.md
# GPIO Line Controller with Four-Way Peripheral Multiplexing

This block controls a parameterised group of up to 32 digital pad lines. Each line either follows software-held output data and output enable (GPIO mode) or passes through the output and output enable of one of four on-chip peripherals. Line n always maps to bit n of every bus word. Output data, output enable, GPIO mode, open-drain (multi-drive) mode, pull-up and a sync-write mask each have a separate set register and clear register, plus a status register for read-back. The two peripheral-select bit planes are written directly.

A masked whole-word output write updates the data of every line whose mask bit is set in a single bus cycle. A pin status register returns the synchronised pad levels, whatever mode a line is in. Peripherals can lock their lines' mode, select, open-drain and pull-up bits. A keyed protection switch can freeze all configuration registers. Refused writes raise a sticky violation flag.

The bus is a simple single-cycle port. Writes take effect at the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`. Offsets are byte addresses, and addresses outside the map read as zero and write nothing.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: After reset every line is in GPIO mode (mode status 0x08 reads all ones). Output data (0x20), output enable (0x14), open-drain (0x2C), pull-up (0x38), both select planes, the mask (0x4C) and the protection register (0x58) read zero, and `pad_oe` is all zero.
- R2: Writing bit n as 1 to a set register sets control bit n. Writing it as 1 to the clear register clears it. Bits written as 0 change nothing. The set/clear/status offsets are: mode 0x00/0x04/0x08, output enable 0x0C/0x10/0x14, data 0x18/0x1C/0x20, open-drain 0x24/0x28/0x2C, pull-up 0x30/0x34/0x38, mask 0x44/0x48/0x4C.
- R3: A line in GPIO mode that is not open-drain drives `pad_out` from its data bit and `pad_oe` from its output-enable bit.
- R4: A line with its mode bit at 0 takes output and enable from peripheral p = {select-high bit, select-low bit}. The select-low plane is at 0x3C and the select-high plane at 0x40, both read/write. Peripheral p's per-line signals sit at `periph_dout[p*N + n]` and `periph_doe[p*N + n]`.
- R5: An open-drain line holds `pad_out` at 0 and asserts `pad_oe` only when its selected source enables the output and drives a 0.
- R6: A write to 0x50 loads bit n of the write data into data bit n only where mask bit n is 1. A read of 0x50 returns the data register.
- R7: Pin status (0x54) and `periph_din` show `pad_in` through a two-flop synchronizer. A level present at a rising edge is visible after the following rising edge.
- R8: `pad_pu` equals the pull-up register.
- R9: While `periph_lock[n]` is 1, writes leave that line's mode, open-drain, pull-up and both select bits unchanged. The other lines of the same write are applied. A write that would change a locked bit sets the violation flag.
- R10: A write to 0x58 whose bits 31:8 equal 0x5A17C3 sets protection to bit 0 of the write data. While protection is on, writes to any set/clear register other than data, and writes to either select plane, are ignored and set the violation flag. Data set/clear and the 0x50 write still work.
- R11: The violation flag reads as bit 1 of 0x58, and protection reads as bit 0. The flag stays set until a write to 0x58 with the correct key clears it. A write to 0x58 with a wrong key sets the flag and leaves protection unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| periph_dout | input | 4*NUM_LINES | Output levels of the four peripherals, peripheral p at slice p |
| periph_doe | input | 4*NUM_LINES | Output enables of the four peripherals |
| periph_lock | input | NUM_LINES | Per-line configuration lock from peripherals |
| periph_din | output | NUM_LINES | Synchronised pad levels for peripherals |
| pad_in | input | NUM_LINES | Pad input levels |
| pad_out | output | NUM_LINES | Pad output levels |
| pad_oe | output | NUM_LINES | Pad output enables |
| pad_pu | output | NUM_LINES | Pad pull-up enables |

## Verification
Register writes land at the rising edge that samples `bus_we`. From then on the pad outputs and the combinational read data show the new state within the same cycle. A change on `pad_in` reaches pin status and `periph_din` two rising edges after it is applied, so the first read one edge later must still return the old level. The bench drives inputs at the falling edge and updates its reference model 1 ns after the write edge. It compares pads and `periph_din` 5 ns after every rising edge and checks reads 2 ns after a falling edge, which keeps every sample clear of the edge that produces it.

// File: rtl/gpio_mux_pkg.sv
`timescale 1ns/1ps
package gpio_mux_pkg;
   localparam int BUS_W = 32;
   localparam int NUM_SRC = 4;

   typedef enum logic [7:0] {
      OFS_MODE_S = 8'h00, OFS_MODE_C = 8'h04, OFS_MODE_R = 8'h08,
      OFS_OE_S   = 8'h0C, OFS_OE_C   = 8'h10, OFS_OE_R   = 8'h14,
      OFS_DAT_S  = 8'h18, OFS_DAT_C  = 8'h1C, OFS_DAT_R  = 8'h20,
      OFS_MD_S   = 8'h24, OFS_MD_C   = 8'h28, OFS_MD_R   = 8'h2C,
      OFS_PU_S   = 8'h30, OFS_PU_C   = 8'h34, OFS_PU_R   = 8'h38,
      OFS_SEL_LO = 8'h3C, OFS_SEL_HI = 8'h40,
      OFS_MSK_S  = 8'h44, OFS_MSK_C  = 8'h48, OFS_MSK_R  = 8'h4C,
      OFS_SYNC   = 8'h50, OFS_PIN    = 8'h54, OFS_PROT   = 8'h58
   } reg_ofs_e;

   typedef struct packed {
      logic mode_s, mode_c, oe_s, oe_c, dat_s, dat_c, md_s, md_c;
      logic pu_s, pu_c, sel_lo, sel_hi, msk_s, msk_c, sync_w, prot_w;
   } wr_strb_t;
endpackage

// File: rtl/gpio_setclr_reg.sv
`timescale 1ns/1ps
module gpio_setclr_reg #(
   parameter int          W       = 32,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic         load_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] allow,
   input  logic [W-1:0] load_mask,
   output logic [W-1:0] q
);
   logic [W-1:0] nxt;

   always_comb begin
      nxt = q;
      if (set_we)  nxt = nxt | (wdata & allow);
      if (clr_we)  nxt = nxt & ~(wdata & allow);
      if (load_we) nxt = (nxt & ~load_mask) | (wdata & load_mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= nxt;
   end
endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
   parameter int N      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   if (STAGES < 0 || STAGES > 4) begin : g_bad
      $error("gpio_in_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_direct
      assign q = d;
   end else begin : g_chain
      logic [N-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign q = stg[STAGES-1];
   end
endmodule

// File: rtl/gpio_line_mux.sv
`timescale 1ns/1ps
module gpio_line_mux
   import gpio_mux_pkg::*;
#(
   parameter int N = 32
) (
   input  logic [N-1:0]         mode,
   input  logic [N-1:0]         dat,
   input  logic [N-1:0]         oe,
   input  logic [N-1:0]         md,
   input  logic [N-1:0]         sel_lo,
   input  logic [N-1:0]         sel_hi,
   input  logic [NUM_SRC*N-1:0] src_dout,
   input  logic [NUM_SRC*N-1:0] src_doe,
   output logic [N-1:0]         pad_out,
   output logic [N-1:0]         pad_oe
);
   for (genvar n = 0; n < N; n++) begin : g_line
      logic [1:0] pick;
      logic       lvl, en;
      always_comb begin
         pick = {sel_hi[n], sel_lo[n]};
         if (mode[n]) begin
            lvl = dat[n];
            en  = oe[n];
         end else begin
            lvl = src_dout[int'(pick) * N + n];
            en  = src_doe[int'(pick) * N + n];
         end
         pad_out[n] = md[n] ? 1'b0 : lvl;
         pad_oe[n]  = md[n] ? (en & ~lvl) : en;
      end
   end
endmodule

// File: rtl/gpio_mux_ctrl.sv
`timescale 1ns/1ps
module gpio_mux_ctrl
   import gpio_mux_pkg::*;
#(
   parameter int                 NUM_LINES   = 32,
   parameter int                 ADDR_W      = 8,
   parameter int                 SYNC_STAGES = 2,
   parameter logic [23:0]        PROT_KEY    = 24'h5A17C3,
   parameter logic [NUM_LINES-1:0] MODE_RST  = '1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_we,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [BUS_W-1:0]             bus_wdata,
   output logic [BUS_W-1:0]             bus_rdata,
   input  logic [NUM_SRC*NUM_LINES-1:0] periph_dout,
   input  logic [NUM_SRC*NUM_LINES-1:0] periph_doe,
   input  logic [NUM_LINES-1:0]         periph_lock,
   output logic [NUM_LINES-1:0]         periph_din,
   input  logic [NUM_LINES-1:0]         pad_in,
   output logic [NUM_LINES-1:0]         pad_out,
   output logic [NUM_LINES-1:0]         pad_oe,
   output logic [NUM_LINES-1:0]         pad_pu
);
   localparam int N = NUM_LINES;
   localparam logic [N-1:0] ALL1 = '1;

   if (N < 1 || N > BUS_W) begin : g_bad_n
      $error("gpio_mux_ctrl: NUM_LINES must be 1..32");
   end
   if (ADDR_W < 8) begin : g_bad_a
      $error("gpio_mux_ctrl: ADDR_W must be at least 8");
   end

   logic [N-1:0] wd;
   reg_ofs_e     ofs;
   logic         ofs_ok;
   wr_strb_t     st;
   logic         cfg_hit, lk_hit, cfg_block, lock_viol, key_ok;
   logic [N-1:0] allow_cfg, allow_lk;
   logic [N-1:0] mode_q, oe_q, dat_q, md_q, pu_q, sel_lo_q, sel_hi_q, msk_q, pin_q;
   logic         prot_en_q, viol_q;
   logic [BUS_W-1:0] rd;

   assign wd     = bus_wdata[N-1:0];
   assign ofs    = reg_ofs_e'(bus_addr[7:0]);
   assign ofs_ok = (bus_addr >> 8) == '0;

   always_comb begin
      st = '0;
      if (bus_we && ofs_ok) begin
         case (ofs)
            OFS_MODE_S: st.mode_s = 1'b1;
            OFS_MODE_C: st.mode_c = 1'b1;
            OFS_OE_S:   st.oe_s   = 1'b1;
            OFS_OE_C:   st.oe_c   = 1'b1;
            OFS_DAT_S:  st.dat_s  = 1'b1;
            OFS_DAT_C:  st.dat_c  = 1'b1;
            OFS_MD_S:   st.md_s   = 1'b1;
            OFS_MD_C:   st.md_c   = 1'b1;
            OFS_PU_S:   st.pu_s   = 1'b1;
            OFS_PU_C:   st.pu_c   = 1'b1;
            OFS_SEL_LO: st.sel_lo = 1'b1;
            OFS_SEL_HI: st.sel_hi = 1'b1;
            OFS_MSK_S:  st.msk_s  = 1'b1;
            OFS_MSK_C:  st.msk_c  = 1'b1;
            OFS_SYNC:   st.sync_w = 1'b1;
            OFS_PROT:   st.prot_w = 1'b1;
            default:    st = '0;
         endcase
      end
   end

   // Protection gate covers every configuration register; lock gate covers line-mux configuration
   assign lk_hit    = st.mode_s | st.mode_c | st.md_s | st.md_c | st.pu_s | st.pu_c;
   assign cfg_hit   = lk_hit | st.oe_s | st.oe_c | st.sel_lo | st.sel_hi | st.msk_s | st.msk_c;
   assign cfg_block = prot_en_q & cfg_hit;
   assign allow_cfg = cfg_block ? '0 : ALL1;
   assign allow_lk  = allow_cfg & ~periph_lock;
   assign lock_viol = ~cfg_block & ((lk_hit & (|(wd & periph_lock)))
                    | (st.sel_lo & (|((wd ^ sel_lo_q) & periph_lock)))
                    | (st.sel_hi & (|((wd ^ sel_hi_q) & periph_lock))));
   assign key_ok    = st.prot_w & (bus_wdata[31:8] == PROT_KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_en_q <= 1'b0;
         viol_q    <= 1'b0;
      end else if (key_ok) begin
         prot_en_q <= bus_wdata[0];
         viol_q    <= 1'b0;
      end else if (cfg_block || lock_viol || st.prot_w) begin
         viol_q    <= 1'b1;
      end
   end

   gpio_setclr_reg #(.W(N), .RST_VAL(MODE_RST)) u_mode (.clk(clk), .rst_n(rst_n),
      .set_we(st.mode_s), .clr_we(st.mode_c), .load_we(1'b0), .wdata(wd),
      .allow(allow_lk), .load_mask('0), .q(mode_q));
   gpio_setclr_reg #(.W(N)) u_oe (.clk(clk), .rst_n(rst_n),
      .set_we(st.oe_s), .clr_we(st.oe_c), .load_we(1'b0), .wdata(wd),
      .allow(allow_cfg), .load_mask('0), .q(oe_q));
   gpio_setclr_reg #(.W(N)) u_dat (.clk(clk), .rst_n(rst_n),
      .set_we(st.dat_s), .clr_we(st.dat_c), .load_we(st.sync_w), .wdata(wd),
      .allow(ALL1), .load_mask(msk_q), .q(dat_q));
   gpio_setclr_reg #(.W(N)) u_md (.clk(clk), .rst_n(rst_n),
      .set_we(st.md_s), .clr_we(st.md_c), .load_we(1'b0), .wdata(wd),
      .allow(allow_lk), .load_mask('0), .q(md_q));
   gpio_setclr_reg #(.W(N)) u_pu (.clk(clk), .rst_n(rst_n),
      .set_we(st.pu_s), .clr_we(st.pu_c), .load_we(1'b0), .wdata(wd),
      .allow(allow_lk), .load_mask('0), .q(pu_q));
   gpio_setclr_reg #(.W(N)) u_sel_lo (.clk(clk), .rst_n(rst_n),
      .set_we(1'b0), .clr_we(1'b0), .load_we(st.sel_lo), .wdata(wd),
      .allow(ALL1), .load_mask(allow_lk), .q(sel_lo_q));
   gpio_setclr_reg #(.W(N)) u_sel_hi (.clk(clk), .rst_n(rst_n),
      .set_we(1'b0), .clr_we(1'b0), .load_we(st.sel_hi), .wdata(wd),
      .allow(ALL1), .load_mask(allow_lk), .q(sel_hi_q));
   gpio_setclr_reg #(.W(N)) u_msk (.clk(clk), .rst_n(rst_n),
      .set_we(st.msk_s), .clr_we(st.msk_c), .load_we(1'b0), .wdata(wd),
      .allow(allow_cfg), .load_mask('0), .q(msk_q));

   gpio_in_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (.clk(clk), .rst_n(rst_n),
      .d(pad_in), .q(pin_q));

   gpio_line_mux #(.N(N)) u_mux (.mode(mode_q), .dat(dat_q), .oe(oe_q), .md(md_q),
      .sel_lo(sel_lo_q), .sel_hi(sel_hi_q), .src_dout(periph_dout), .src_doe(periph_doe),
      .pad_out(pad_out), .pad_oe(pad_oe));

   assign pad_pu     = pu_q;
   assign periph_din = pin_q;

   always_comb begin
      rd = '0;
      if (ofs_ok) begin
         case (ofs)
            OFS_MODE_R: rd[N-1:0] = mode_q;
            OFS_OE_R:   rd[N-1:0] = oe_q;
            OFS_DAT_R,
            OFS_SYNC:   rd[N-1:0] = dat_q;
            OFS_MD_R:   rd[N-1:0] = md_q;
            OFS_PU_R:   rd[N-1:0] = pu_q;
            OFS_SEL_LO: rd[N-1:0] = sel_lo_q;
            OFS_SEL_HI: rd[N-1:0] = sel_hi_q;
            OFS_MSK_R:  rd[N-1:0] = msk_q;
            OFS_PIN:    rd[N-1:0] = pin_q;
            OFS_PROT:   rd[1:0]   = {viol_q, prot_en_q};
            default:    rd = '0;
         endcase
      end
   end
   assign bus_rdata = rd;
endmodule

// File: rtl/gpio_mux_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_mux_ctrl_chk
   import gpio_mux_pkg::*;
#(
   parameter int N      = 32,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic [N-1:0]      periph_lock,
   input logic [N-1:0]      pad_out,
   input logic [N-1:0]      pad_oe,
   input logic [N-1:0]      mode_q,
   input logic [N-1:0]      oe_q,
   input logic [N-1:0]      dat_q,
   input logic [N-1:0]      md_q,
   input logic [N-1:0]      pu_q,
   input logic [N-1:0]      sel_lo_q,
   input logic [N-1:0]      sel_hi_q,
   input logic [N-1:0]      msk_q,
   input logic              prot_en_q,
   input logic              viol_q
);
   logic         cfg_wr, prot_wr, sync_wr;
   logic [N-1:0] lk_cfg;

   assign prot_wr = bus_we && (bus_addr == ADDR_W'(OFS_PROT));
   assign sync_wr = bus_we && (bus_addr == ADDR_W'(OFS_SYNC));
   assign cfg_wr  = bus_we && (bus_addr == ADDR_W'(OFS_MODE_S) || bus_addr == ADDR_W'(OFS_MODE_C)
                 || bus_addr == ADDR_W'(OFS_OE_S) || bus_addr == ADDR_W'(OFS_OE_C)
                 || bus_addr == ADDR_W'(OFS_MD_S) || bus_addr == ADDR_W'(OFS_MD_C)
                 || bus_addr == ADDR_W'(OFS_PU_S) || bus_addr == ADDR_W'(OFS_PU_C)
                 || bus_addr == ADDR_W'(OFS_SEL_LO) || bus_addr == ADDR_W'(OFS_SEL_HI)
                 || bus_addr == ADDR_W'(OFS_MSK_S) || bus_addr == ADDR_W'(OFS_MSK_C));
   assign lk_cfg  = mode_q ^ md_q ^ pu_q ^ sel_lo_q ^ sel_hi_q;

   // R5: an open-drain line never drives a high level
   a_r5_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & pad_out & md_q) == '0);

   // R9: locked lines keep their line-mux configuration
   a_r9_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (((mode_q ^ $past(mode_q)) | (md_q ^ $past(md_q)) | (pu_q ^ $past(pu_q))
        | (sel_lo_q ^ $past(sel_lo_q)) | (sel_hi_q ^ $past(sel_hi_q))) & $past(periph_lock)) == '0);

   // R10: a configuration write under protection changes no configuration
   a_r10_prot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_en_q && cfg_wr) |=> ($stable(oe_q) && $stable(msk_q) && $stable(lk_cfg) && viol_q));

   // R11: the violation flag holds until a protection-register write
   a_r11_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_q && !prot_wr) |=> viol_q);

   // R6: masked lines take the whole-word write value
   a_r6_sync_masked: assert property (@(posedge clk) disable iff (!rst_n)
      sync_wr |=> (((dat_q ^ $past(bus_wdata[N-1:0])) & $past(msk_q)) == '0));
endmodule

bind gpio_mux_ctrl gpio_mux_ctrl_chk #(.N(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .periph_lock(periph_lock), .pad_out(pad_out), .pad_oe(pad_oe), .mode_q(mode_q),
   .oe_q(oe_q), .dat_q(dat_q), .md_q(md_q), .pu_q(pu_q), .sel_lo_q(sel_lo_q),
   .sel_hi_q(sel_hi_q), .msk_q(msk_q), .prot_en_q(prot_en_q), .viol_q(viol_q));

// File: tb/gpio_mux_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_mux_ctrl_bench;
   localparam int N = 32;
   localparam logic [23:0] KEY = 24'h5A17C3;
   localparam logic [7:0] A_MODE_S=8'h00, A_MODE_C=8'h04, A_MODE_R=8'h08, A_OE_S=8'h0C,
      A_OE_C=8'h10, A_OE_R=8'h14, A_DAT_S=8'h18, A_DAT_C=8'h1C, A_DAT_R=8'h20, A_MD_S=8'h24,
      A_MD_C=8'h28, A_MD_R=8'h2C, A_PU_S=8'h30, A_PU_C=8'h34, A_PU_R=8'h38, A_SLO=8'h3C,
      A_SHI=8'h40, A_MSK_S=8'h44, A_MSK_C=8'h48, A_MSK_R=8'h4C, A_SYNC=8'h50, A_PIN=8'h54,
      A_PROT=8'h58;

   logic clk = 1'b0, rst_n = 1'b0;
   always #10 clk = ~clk;

   logic         bus_we = 1'b0;
   logic [7:0]   bus_addr = '0;
   logic [31:0]  bus_wdata = '0, bus_rdata;
   logic [4*N-1:0] periph_dout = '0, periph_doe = '0;
   logic [N-1:0] periph_lock = '0, periph_din, pad_in = '0, pad_out, pad_oe, pad_pu;

   gpio_mux_ctrl u_gpio_mux_ctrl (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_dout(periph_dout),
      .periph_doe(periph_doe), .periph_lock(periph_lock), .periph_din(periph_din),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu));

   int total = 0, bad = 0;
   bit done = 1'b0;

   // reference state
   logic [31:0] m_mode = '1, m_oe = '0, m_dat = '0, m_md = '0, m_pu = '0;
   logic [31:0] m_slo = '0, m_shi = '0, m_msk = '0, h0 = '0, h1 = '0;
   logic        m_pen = 1'b0, m_viol = 1'b0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic void exp_pads(output logic [31:0] o, output logic [31:0] e);
      for (int n = 0; n < N; n++) begin
         logic lv, en;
         int p;
         p  = 2 * int'(m_shi[n]) + int'(m_slo[n]);
         lv = m_mode[n] ? m_dat[n] : periph_dout[p*N+n];
         en = m_mode[n] ? m_oe[n]  : periph_doe[p*N+n];
         o[n] = m_md[n] ? 1'b0 : lv;
         e[n] = m_md[n] ? (en & ~lv) : en;
      end
   endfunction

   function automatic logic [31:0] m_read(input logic [7:0] a);
      case (a)
         A_MODE_R: return m_mode;
         A_OE_R:   return m_oe;
         A_DAT_R, A_SYNC: return m_dat;
         A_MD_R:   return m_md;
         A_PU_R:   return m_pu;
         A_SLO:    return m_slo;
         A_SHI:    return m_shi;
         A_MSK_R:  return m_msk;
         A_PIN:    return h1;
         A_PROT:   return {30'd0, m_viol, m_pen};
         default:  return '0;
      endcase
   endfunction

   function automatic void m_write(input logic [7:0] a, input logic [31:0] d);
      logic [31:0] lk, ok;
      bit cfg, lockable;
      lk = periph_lock;
      ok = d & ~lk;
      cfg = a inside {A_MODE_S, A_MODE_C, A_OE_S, A_OE_C, A_MD_S, A_MD_C, A_PU_S, A_PU_C,
                      A_SLO, A_SHI, A_MSK_S, A_MSK_C};
      lockable = a inside {A_MODE_S, A_MODE_C, A_MD_S, A_MD_C, A_PU_S, A_PU_C};
      if (cfg && m_pen) begin
         m_viol = 1'b1;
         return;
      end
      if (lockable && (d & lk) != 0) m_viol = 1'b1;
      case (a)
         A_MODE_S: m_mode |= ok;
         A_MODE_C: m_mode &= ~ok;
         A_OE_S:   m_oe |= d;
         A_OE_C:   m_oe &= ~d;
         A_DAT_S:  m_dat |= d;
         A_DAT_C:  m_dat &= ~d;
         A_MD_S:   m_md |= ok;
         A_MD_C:   m_md &= ~ok;
         A_PU_S:   m_pu |= ok;
         A_PU_C:   m_pu &= ~ok;
         A_MSK_S:  m_msk |= d;
         A_MSK_C:  m_msk &= ~d;
         A_SYNC:   m_dat = (m_dat & ~m_msk) | (d & m_msk);
         A_SLO: begin
            if (((d ^ m_slo) & lk) != 0) m_viol = 1'b1;
            m_slo = (m_slo & lk) | ok;
         end
         A_SHI: begin
            if (((d ^ m_shi) & lk) != 0) m_viol = 1'b1;
            m_shi = (m_shi & lk) | ok;
         end
         A_PROT: begin
            if (d[31:8] == KEY) begin
               m_pen  = d[0];
               m_viol = 1'b0;
            end else m_viol = 1'b1;
         end
         default: ;
      endcase
   endfunction

   // per-cycle comparison of pad-side outputs, 5 ns after each rising edge
   initial begin
      logic [31:0] eo, ee;
      forever begin
         @(posedge clk);
         if (!rst_n) begin h0 = '0; h1 = '0; end
         else begin h1 = h0; h0 = pad_in; end
         #5;
         if (rst_n && !done) begin
            exp_pads(eo, ee);
            check("R3/R4/R5 pad_out", pad_out, eo);
            check("R3/R4/R5 pad_oe", pad_oe, ee);
            check("R8 pad_pu", pad_pu, m_pu);
            check("R7 periph_din", periph_din, h1);
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 m_write(a, d);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_lit(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a;
      #2 check(tag, bus_rdata, exp);
      check({tag, " model"}, bus_rdata, m_read(a));
   endtask

   task automatic rd_mdl(input logic [7:0] a);
      @(negedge clk);
      bus_addr = a;
      #2 check("R2/R11 readback", bus_rdata, m_read(a));
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] addrs [23] = '{A_MODE_S, A_MODE_C, A_MODE_R, A_OE_S, A_OE_C, A_OE_R,
         A_DAT_S, A_DAT_C, A_DAT_R, A_MD_S, A_MD_C, A_MD_R, A_PU_S, A_PU_C, A_PU_R, A_SLO,
         A_SHI, A_MSK_S, A_MSK_C, A_MSK_R, A_SYNC, A_PIN, A_PROT};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd_lit(A_MODE_R, 32'hFFFF_FFFF, "R1 mode");
      rd_lit(A_OE_R, 32'h0, "R1 oe");
      rd_lit(A_DAT_R, 32'h0, "R1 data");
      rd_lit(A_PROT, 32'h0, "R1 prot");
      check("R1 pad_oe", pad_oe, 32'h0);
      // R2 set/clear
      wr(A_OE_S, 32'h0000_FFFF);
      wr(A_DAT_S, 32'hA5A5_00FF);
      wr(A_DAT_C, 32'h0000_000F);
      wr(A_OE_C, 32'h0);
      rd_lit(A_DAT_R, 32'hA5A5_00F0, "R2 data");
      rd_lit(A_OE_R, 32'h0000_FFFF, "R2 oe zero-bits");
      // R3 GPIO drive
      check("R3 pad_out", pad_out, 32'hA5A5_00F0);
      check("R3 pad_oe", pad_oe, 32'h0000_FFFF);
      // R4 peripheral mux
      periph_dout = {32'h0F0F_0F0F, 32'hAAAA_AAAA, 32'hFFFF_FFFF, 32'h0};
      periph_doe  = '1;
      wr(A_MODE_C, 32'hFFFF_0000);
      wr(A_SLO, 32'hFF00_0000);
      wr(A_SHI, 32'hF0F0_0000);
      check("R4 pad_out", pad_out, 32'h0FA0_00F0);
      check("R4 pad_oe", pad_oe, 32'hFFFF_FFFF);
      // R5 open drain
      wr(A_MD_S, 32'h0000_00F3);
      check("R5 pad_out", pad_out, 32'h0FA0_0000);
      check("R5 pad_oe", pad_oe, 32'hFFFF_FF0F);
      // R8 pull-up
      wr(A_PU_S, 32'h1234_5678);
      check("R8 pad_pu", pad_pu, 32'h1234_5678);
      // R6 masked whole-word write
      wr(A_MSK_S, 32'h0000_FF00);
      wr(A_SYNC, 32'hFFFF_5A00);
      rd_lit(A_DAT_R, 32'hA5A5_5AF0, "R6 data");
      rd_lit(A_SYNC, 32'hA5A5_5AF0, "R6 sync readback");
      // R7 synchronizer latency
      @(negedge clk) pad_in = 32'h1357_9BDF;
      rd_lit(A_PIN, 32'h0, "R7 one edge");
      rd_lit(A_PIN, 32'h1357_9BDF, "R7 two edges");
      // R9 lock
      periph_lock = 32'h0000_00FF;
      wr(A_MODE_C, 32'h0000_01FF);
      rd_lit(A_MODE_R, 32'h0000_FEFF, "R9 mode");
      wr(A_PU_C, 32'hFFFF_FFFF);
      rd_lit(A_PU_R, 32'h0000_0078, "R9 pullup");
      rd_lit(A_PROT, 32'h2, "R9 violation");
      wr(A_PROT, {KEY, 8'h00});
      rd_lit(A_PROT, 32'h0, "R11 cleared");
      periph_lock = 32'h0100_0000;
      wr(A_SLO, 32'h0);
      rd_lit(A_SLO, 32'h0100_0000, "R9 select");
      rd_lit(A_PROT, 32'h2, "R9 select violation");
      periph_lock = '0;
      // R10 protection
      wr(A_PROT, {KEY, 8'h01});
      rd_lit(A_PROT, 32'h1, "R10 enabled");
      wr(A_OE_S, 32'hFFFF_0000);
      rd_lit(A_OE_R, 32'h0000_FFFF, "R10 oe held");
      rd_lit(A_PROT, 32'h3, "R10 violation");
      wr(A_DAT_S, 32'h0F00_0000);
      rd_lit(A_DAT_R, 32'hAFA5_5AF0, "R10 data still open");
      // R11 wrong key
      wr(A_PROT, 32'h1234_5600);
      rd_lit(A_PROT, 32'h3, "R11 wrong key");
      wr(A_PROT, {KEY, 8'h00});
      rd_lit(A_PROT, 32'h0, "R11 key clears");
      // mixed traffic against the model
      for (int i = 0; i < 600; i++) begin
         logic [7:0]  a;
         logic [31:0] d;
         a = addrs[$urandom_range(22, 0)];
         d = $urandom;
         if (a == A_PROT && $urandom_range(1, 0) == 1) d = {KEY, 7'd0, d[0]};
         @(negedge clk);
         pad_in      = $urandom;
         periph_dout = {$urandom, $urandom, $urandom, $urandom};
         periph_doe  = {$urandom, $urandom, $urandom, $urandom};
         periph_lock = ($urandom_range(3, 0) == 0) ? 32'($urandom) : '0;
         wr(a, d);
         rd_mdl(addrs[$urandom_range(22, 0)]);
      end
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule